// File: doc/BRIEF.md
# Security-Partitioned System Control Register Bank

This block holds a handful of system control registers for a processor core that runs in a secure and a non-secure world. Each request names a register through four selector fields (an opcode-1 field, a primary register number, a secondary register number and an opcode-2 field) and carries the current world, a privilege flag and a lock input that blocks secure updates of the translation table base. The bank checks every request against the world and the privilege level. Depending on that check, a request returns data, is treated as read-only, or is refused with an undefined-instruction flag.

The bank holds four registers. The first routes external aborts. The second grants debug rights in secure user mode. The third grants the non-secure world access to coprocessors, DMA and lockdown entries. The fourth is a translation table base register with one copy per world. The stored fields also drive decoded control outputs, so the rest of the core reads them as plain wires. The response is registered: read data and the undefined flag appear in the cycle after the request.

Top module: `sec_ctrl_bank`

## Requirements
- R1: With opcode1=0, CRn=1 and CRm=1, opcode2 values 0, 1 and 2 select the abort-routing register, the secure-debug register and the non-secure-access register. Opcode1=0, CRn=2, CRm=0 and opcode2=0 selects the translation table base. Any other selector raises the undefined flag.
- R2: The response to a request accepted at a clock edge appears after that edge. The undefined flag is high for exactly that one cycle when the request is refused. `rd_data` is zero after a refused request, after an accepted write, and in any cycle that follows no request.
- R3: The abort-routing register can be read or written only in secure privileged mode; any other access is refused. It stores bit0 (EA) and bit1 (AW); all its other bits read as zero.
- R4: `abort_route` is 0 (handle locally) when EA=0. It is 1 (trap all external aborts to the monitor) when EA=1 and AW=0, and 2 (trap only imprecise data aborts) when EA=1 and AW=1.
- R5: The secure-debug register can be accessed only in secure privileged mode. Bit1 drives `sec_user_noninv_dbg` and bit0 drives `sec_user_inv_dbg`. Bits [31:2] read as zero.
- R6: The non-secure-access register is read/write in secure privileged mode and read-only in non-secure privileged mode. A non-secure write or any user-mode access is refused.
- R7: Non-secure-access fields: bit18 drives `ns_dma_en`, bit17 drives `ns_tlb_lock_en`, bit16 drives `ns_cache_lock_en`, and bits [13:0] drive `ns_cp_en`. Bits [31:19] and [15:14] read as zero.
- R8: The translation table base keeps one copy per world, and the current world picks the copy that is accessed. Privileged modes of either world may read and write their own copy. User mode is refused.
- R9: A translation table base write in secure privileged mode while `s_wr_lock` is high is refused and leaves the copy unchanged. The lock has no effect on non-secure writes.
- R10: A translation table base write stores bits [31:7] (base), [4:3] (walk region attribute), bit1 (shared) and bit0 (inner cacheable). Bit2 and bits [6:5] read as zero. Each copy drives its world's base and walk attribute outputs.
- R11: A refused request changes no register and no decoded output.
- R12: After reset all stored fields and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| sel_op1 | input | 3 | Opcode-1 selector field |
| sel_crn | input | 4 | Primary register number |
| sel_crm | input | 4 | Secondary register number |
| sel_op2 | input | 3 | Opcode-2 selector field |
| wr_data | input | 32 | Write data |
| cur_ns | input | 1 | Current world, 1 = non-secure |
| cur_priv | input | 1 | 1 = privileged mode |
| s_wr_lock | input | 1 | Blocks secure translation-base writes |
| rd_data | output | 32 | Read data of the previous request |
| undef_pulse | output | 1 | Previous request was refused |
| abort_route | output | 2 | 0 local, 1 trap all external, 2 trap imprecise only |
| sec_user_noninv_dbg | output | 1 | Non-invasive debug allowed in secure user mode |
| sec_user_inv_dbg | output | 1 | Invasive debug allowed in secure user mode |
| ns_cp_en | output | 14 | Per-coprocessor non-secure access allowed |
| ns_dma_en | output | 1 | DMA usable by the non-secure world |
| ns_tlb_lock_en | output | 1 | TLB lockdown available to non-secure world |
| ns_cache_lock_en | output | 1 | Cache lockdown available to non-secure world |
| s_tt_base | output | 25 | Secure copy base address bits [31:7] |
| s_walk_attr | output | 4 | Secure copy {region[1:0], shared, inner} |
| ns_tt_base | output | 25 | Non-secure copy base address bits [31:7] |
| ns_walk_attr | output | 4 | Non-secure copy {region[1:0], shared, inner} |

## Verification
Each register is accessed under all four combinations of world and privilege. The outcomes for one request therefore separate three cases: data returned, write refused while the read still works, and a refused access. The abort-routing bits are written in all four AW/EA combinations, which tells apart an exact decode from one that looks at only one bit. The translation table base is written with all ones and then with a sparse pattern in one world. Reading back from both worlds then shows whether the copies are banked and which bits are masked. Repeating the secure write with the lock set and then the non-secure write with the lock set shows that the lock applies only to the secure copy. Unmapped selectors that differ from a valid one in a single field confirm that the decode checks every field.

// File: rtl/sec_bank_pkg.sv
package sec_bank_pkg;
   typedef enum logic [2:0] {
      REG_NONE  = 3'd0,
      REG_ABT   = 3'd1,
      REG_DBG   = 3'd2,
      REG_NSACC = 3'd3,
      REG_TTB   = 3'd4
   } reg_id_e;

   typedef enum logic [1:0] {
      ROUTE_LOCAL    = 2'd0,
      ROUTE_TRAP_ALL = 2'd1,
      ROUTE_TRAP_IMP = 2'd2
   } abort_route_e;

   function automatic logic [1:0] route_of(input logic aw, input logic ea);
      if (!ea)     return ROUTE_LOCAL;
      else if (aw) return ROUTE_TRAP_IMP;
      else         return ROUTE_TRAP_ALL;
   endfunction
endpackage

// File: rtl/sec_bank_decode.sv
module sec_bank_decode
   import sec_bank_pkg::*;
(
   input  logic       wr,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   input  logic       ns,
   input  logic       priv,
   input  logic       lock,
   output reg_id_e    reg_id,
   output logic       grant
);
   always_comb begin
      reg_id = REG_NONE;
      if (op1 == 3'd0 && crn == 4'd1 && crm == 4'd1) begin
         unique case (op2)
            3'd0:    reg_id = REG_ABT;
            3'd1:    reg_id = REG_DBG;
            3'd2:    reg_id = REG_NSACC;
            default: reg_id = REG_NONE;
         endcase
      end else if (op1 == 3'd0 && crn == 4'd2 && crm == 4'd0 && op2 == 3'd0) begin
         reg_id = REG_TTB;
      end
   end

   always_comb begin
      unique case (reg_id)
         REG_ABT, REG_DBG: grant = priv && !ns;
         REG_NSACC:        grant = priv && !(wr && ns);
         REG_TTB:          grant = priv && !(wr && !ns && lock);
         default:          grant = 1'b0;
      endcase
   end
endmodule

// File: rtl/sec_bank_ttb.sv
module sec_bank_ttb #(
   parameter int DATA_W   = 32,
   parameter int BASE_LSB = 7,
   localparam int BASE_W  = DATA_W - BASE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [3:0]        wr_attr,
   output logic [BASE_W-1:0] base,
   output logic [3:0]        attr,
   output logic [DATA_W-1:0] view
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         attr <= '0;
      end else if (wr_en) begin
         base <= wr_base;
         attr <= wr_attr;
      end
   end

   // attr = {region[1:0], shared, inner}; ECC flag position forced to zero
   always_comb begin
      view                       = '0;
      view[DATA_W-1:BASE_LSB]    = base;
      view[4:3]                  = attr[3:2];
      view[1:0]                  = attr[1:0];
   end
endmodule

// File: rtl/sec_ctrl_bank.sv
module sec_ctrl_bank
   import sec_bank_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CP_NUM   = 14,
   parameter int BASE_LSB = 7,
   localparam int BASE_W  = DATA_W - BASE_LSB,
   localparam int WORLDS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [2:0]        sel_op1,
   input  logic [3:0]        sel_crn,
   input  logic [3:0]        sel_crm,
   input  logic [2:0]        sel_op2,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cur_ns,
   input  logic              cur_priv,
   input  logic              s_wr_lock,
   output logic [DATA_W-1:0] rd_data,
   output logic              undef_pulse,
   output logic [1:0]        abort_route,
   output logic              sec_user_noninv_dbg,
   output logic              sec_user_inv_dbg,
   output logic [CP_NUM-1:0] ns_cp_en,
   output logic              ns_dma_en,
   output logic              ns_tlb_lock_en,
   output logic              ns_cache_lock_en,
   output logic [BASE_W-1:0] s_tt_base,
   output logic [3:0]        s_walk_attr,
   output logic [BASE_W-1:0] ns_tt_base,
   output logic [3:0]        ns_walk_attr
);
   localparam int NS_CACHE_BIT = 16;
   localparam int NS_TLB_BIT   = 17;
   localparam int NS_DMA_BIT   = 18;

   if (DATA_W != 32) begin : g_bad_width
      $error("sec_ctrl_bank: DATA_W must be 32");
   end
   if (CP_NUM < 1 || CP_NUM > 14) begin : g_bad_cp
      $error("sec_ctrl_bank: CP_NUM must be 1..14");
   end
   if (BASE_LSB < 7 || BASE_LSB > 14) begin : g_bad_lsb
      $error("sec_ctrl_bank: BASE_LSB must be 7..14");
   end

   reg_id_e rid;
   logic    grant;

   sec_bank_decode u_dec (
      .wr     (req_write),
      .op1    (sel_op1),
      .crn    (sel_crn),
      .crm    (sel_crm),
      .op2    (sel_op2),
      .ns     (cur_ns),
      .priv   (cur_priv),
      .lock   (s_wr_lock),
      .reg_id (rid),
      .grant  (grant)
   );

   logic acc_ok, wr_ok;
   assign acc_ok = req_valid && grant;
   assign wr_ok  = acc_ok && req_write;

   // abort routing and debug bits
   logic aw_q, ea_q, dni_q, di_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aw_q <= 1'b0; ea_q <= 1'b0; dni_q <= 1'b0; di_q <= 1'b0;
      end else begin
         if (wr_ok && rid == REG_ABT) begin
            ea_q <= wr_data[0];
            aw_q <= wr_data[1];
         end
         if (wr_ok && rid == REG_DBG) begin
            di_q  <= wr_data[0];
            dni_q <= wr_data[1];
         end
      end
   end

   // non-secure access grants
   logic [CP_NUM-1:0] cp_q;
   logic              dma_q, tlb_q, cache_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cp_q <= '0; dma_q <= 1'b0; tlb_q <= 1'b0; cache_q <= 1'b0;
      end else if (wr_ok && rid == REG_NSACC) begin
         cp_q    <= wr_data[CP_NUM-1:0];
         dma_q   <= wr_data[NS_DMA_BIT];
         tlb_q   <= wr_data[NS_TLB_BIT];
         cache_q <= wr_data[NS_CACHE_BIT];
      end
   end

   // world-banked translation table base, index 0 secure, 1 non-secure
   logic [BASE_W-1:0] tb_base [WORLDS];
   logic [3:0]        tb_attr [WORLDS];
   logic [DATA_W-1:0] tb_view [WORLDS];

   for (genvar w = 0; w < WORLDS; w++) begin : g_world
      sec_bank_ttb #(.DATA_W(DATA_W), .BASE_LSB(BASE_LSB)) u_ttb (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_ok && rid == REG_TTB && (cur_ns == (w == 1))),
         .wr_base (wr_data[DATA_W-1:BASE_LSB]),
         .wr_attr ({wr_data[4:3], wr_data[1:0]}),
         .base    (tb_base[w]),
         .attr    (tb_attr[w]),
         .view    (tb_view[w])
      );
   end

   // read mux
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (rid)
         REG_ABT:   rd_mux[1:0] = {aw_q, ea_q};
         REG_DBG:   rd_mux[1:0] = {dni_q, di_q};
         REG_NSACC: begin
            rd_mux[CP_NUM-1:0]  = cp_q;
            rd_mux[NS_DMA_BIT]  = dma_q;
            rd_mux[NS_TLB_BIT]  = tlb_q;
            rd_mux[NS_CACHE_BIT] = cache_q;
         end
         REG_TTB:   rd_mux = tb_view[cur_ns ? 1 : 0];
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data     <= '0;
         undef_pulse <= 1'b0;
      end else begin
         undef_pulse <= req_valid && !grant;
         rd_data     <= (acc_ok && !req_write) ? rd_mux : '0;
      end
   end

   logic wr_data_unused;
   assign wr_data_unused = ^{wr_data[15:CP_NUM], wr_data[6:5], wr_data[2],
                             wr_data[DATA_W-1:NS_DMA_BIT+1]};

   assign abort_route         = route_of(aw_q, ea_q);
   assign sec_user_noninv_dbg = dni_q;
   assign sec_user_inv_dbg    = di_q;
   assign ns_cp_en            = cp_q;
   assign ns_dma_en           = dma_q;
   assign ns_tlb_lock_en      = tlb_q;
   assign ns_cache_lock_en    = cache_q;
   assign s_tt_base           = tb_base[0];
   assign s_walk_attr         = tb_attr[0];
   assign ns_tt_base          = tb_base[1];
   assign ns_walk_attr        = tb_attr[1];
endmodule

// File: rtl/sec_ctrl_bank_chk.sv
module sec_ctrl_bank_chk #(
   parameter int DATA_W = 32,
   parameter int CP_NUM = 14,
   parameter int BASE_W = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [2:0]        sel_op1,
   input logic [3:0]        sel_crn,
   input logic [3:0]        sel_crm,
   input logic [2:0]        sel_op2,
   input logic              cur_ns,
   input logic              cur_priv,
   input logic              s_wr_lock,
   input logic [DATA_W-1:0] rd_data,
   input logic              undef_pulse,
   input logic [1:0]        abort_route,
   input logic [CP_NUM-1:0] ns_cp_en,
   input logic              ns_dma_en,
   input logic [BASE_W-1:0] s_tt_base,
   input logic [BASE_W-1:0] ns_tt_base
);
   logic sel_ttb;
   assign sel_ttb = sel_op1 == 3'd0 && sel_crn == 4'd2 && sel_crm == 4'd0 && sel_op2 == 3'd0;

   p_user_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !cur_priv |=> undef_pulse);

   p_flag_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      undef_pulse |-> $past(req_valid));

   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> rd_data == '0 && !undef_pulse);

   p_refused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      undef_pulse |-> rd_data == '0);

   p_refused_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      undef_pulse |-> $stable(ns_cp_en) && $stable(ns_dma_en) && $stable(abort_route)
                      && $stable(s_tt_base) && $stable(ns_tt_base));

   p_lock_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && sel_ttb && cur_priv && !cur_ns && s_wr_lock |=> undef_pulse);

   p_route_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_route != 2'd3);
endmodule

bind sec_ctrl_bank sec_ctrl_bank_chk #(.DATA_W(DATA_W), .CP_NUM(CP_NUM), .BASE_W(BASE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .sel_op1(sel_op1), .sel_crn(sel_crn), .sel_crm(sel_crm), .sel_op2(sel_op2),
   .cur_ns(cur_ns), .cur_priv(cur_priv), .s_wr_lock(s_wr_lock),
   .rd_data(rd_data), .undef_pulse(undef_pulse), .abort_route(abort_route),
   .ns_cp_en(ns_cp_en), .ns_dma_en(ns_dma_en),
   .s_tt_base(s_tt_base), .ns_tt_base(ns_tt_base)
);

// File: tb/sim_sec_ctrl_bank.sv
module sim_sec_ctrl_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0;
   logic [2:0]  sel_op1 = 0, sel_op2 = 0;
   logic [3:0]  sel_crn = 0, sel_crm = 0;
   logic [31:0] wr_data = 0;
   logic        cur_ns = 0, cur_priv = 0, s_wr_lock = 0;
   logic [31:0] rd_data;
   logic        undef_pulse;
   logic [1:0]  abort_route;
   logic        sec_user_noninv_dbg, sec_user_inv_dbg;
   logic [13:0] ns_cp_en;
   logic        ns_dma_en, ns_tlb_lock_en, ns_cache_lock_en;
   logic [24:0] s_tt_base, ns_tt_base;
   logic [3:0]  s_walk_attr, ns_walk_attr;

   int checks = 0, fails = 0;
   logic [31:0] r_data;
   logic        r_undef;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_ctrl_bank u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one request; results sampled on the negedge after the capturing posedge
   task automatic acc(input logic wr, input logic [2:0] o1, input logic [3:0] cn,
                      input logic [3:0] cm, input logic [2:0] o2, input logic [31:0] d,
                      input logic ns, input logic pv, input logic lk);
      @(negedge clk);
      req_valid = 1; req_write = wr; sel_op1 = o1; sel_crn = cn; sel_crm = cm;
      sel_op2 = o2; wr_data = d; cur_ns = ns; cur_priv = pv; s_wr_lock = lk;
      @(negedge clk);
      r_data = rd_data; r_undef = undef_pulse;
      req_valid = 0; req_write = 0; s_wr_lock = 0;
   endtask

   task automatic acc_reg(input int sel, input logic wr, input logic [31:0] d,
                          input logic ns, input logic pv, input logic lk);
      case (sel)
         0: acc(wr, 3'd0, 4'd1, 4'd1, 3'd0, d, ns, pv, lk);
         1: acc(wr, 3'd0, 4'd1, 4'd1, 3'd1, d, ns, pv, lk);
         2: acc(wr, 3'd0, 4'd1, 4'd1, 3'd2, d, ns, pv, lk);
         default: acc(wr, 3'd0, 4'd2, 4'd0, 3'd0, d, ns, pv, lk);
      endcase
   endtask

   task automatic t_reset();
      chk("R12 rd_data", rd_data, 0);
      chk("R12 undef", {31'b0, undef_pulse}, 0);
      chk("R12 route", {30'b0, abort_route}, 0);
      chk("R12 cp", {18'b0, ns_cp_en}, 0);
      chk("R12 ttb", {7'b0, s_tt_base} | {7'b0, ns_tt_base}, 0);
      acc_reg(3, 0, 0, 0, 1, 0);
      chk("R12 ttb read", r_data, 0);
   endtask

   task automatic t_abort();
      for (int v = 0; v < 4; v++) begin
         logic [1:0] exp;
         exp = (v[0] == 0) ? 2'd0 : (v[1] ? 2'd2 : 2'd1);
         acc_reg(0, 1, 32'hFFFF_FFFC | v, 0, 1, 0);
         chk("R3 write ok", {31'b0, r_undef}, 0);
         chk("R2 write rdata zero", r_data, 0);
         chk("R4 route", {30'b0, abort_route}, {30'b0, exp});
         acc_reg(0, 0, 0, 0, 1, 0);
         chk("R3 readback", r_data, v);
      end
      acc_reg(0, 0, 0, 1, 1, 0);
      chk("R3 ns read undef", {31'b0, r_undef}, 1);
      chk("R2 refused rdata", r_data, 0);
      acc_reg(0, 1, 0, 0, 0, 0);
      chk("R3 user write undef", {31'b0, r_undef}, 1);
      chk("R11 route kept", {30'b0, abort_route}, 2);
      @(negedge clk);
      chk("R2 one cycle flag", {31'b0, undef_pulse}, 0);
   endtask

   task automatic t_debug();
      acc_reg(1, 1, 32'hFFFF_FFFE, 0, 1, 0);
      chk("R5 noninv", {31'b0, sec_user_noninv_dbg}, 1);
      chk("R5 inv", {31'b0, sec_user_inv_dbg}, 0);
      acc_reg(1, 0, 0, 0, 1, 0);
      chk("R5 read", r_data, 32'h2);
      acc_reg(1, 1, 32'h1, 1, 1, 0);
      chk("R5 ns write undef", {31'b0, r_undef}, 1);
      chk("R11 dbg kept", {30'b0, sec_user_noninv_dbg, sec_user_inv_dbg}, 2);
   endtask

   task automatic t_nsacc();
      acc_reg(2, 1, 32'hFFFF_FFFF, 0, 1, 0);
      chk("R7 cp", {18'b0, ns_cp_en}, 32'h3FFF);
      chk("R7 dma/tlb/cache", {29'b0, ns_dma_en, ns_tlb_lock_en, ns_cache_lock_en}, 7);
      acc_reg(2, 0, 0, 1, 1, 0);
      chk("R6 ns read ok", {31'b0, r_undef}, 0);
      chk("R7 read layout", r_data, 32'h0007_3FFF);
      acc_reg(2, 1, 32'h0, 1, 1, 0);
      chk("R6 ns write undef", {31'b0, r_undef}, 1);
      chk("R11 cp kept", {18'b0, ns_cp_en}, 32'h3FFF);
      acc_reg(2, 0, 0, 0, 0, 0);
      chk("R6 user read undef", {31'b0, r_undef}, 1);
      acc_reg(2, 1, 32'h0004_0005, 0, 1, 0);
      chk("R7 sparse", {12'b0, ns_dma_en, ns_tlb_lock_en, ns_cache_lock_en, 3'b0, ns_cp_en},
          32'h0008_0005);
   endtask

   task automatic t_ttb();
      acc_reg(3, 1, 32'hFFFF_FFFF, 0, 1, 0);
      chk("R10 s base", {7'b0, s_tt_base}, 32'h01FF_FFFF);
      chk("R10 s attr", {28'b0, s_walk_attr}, 32'hF);
      acc_reg(3, 0, 0, 0, 1, 0);
      chk("R10 masked read", r_data, 32'hFFFF_FF9B);
      acc_reg(3, 0, 0, 1, 1, 0);
      chk("R8 ns copy separate", r_data, 0);
      acc_reg(3, 1, 32'h1234_5689, 1, 1, 1);
      chk("R9 ns write ignores lock", {31'b0, r_undef}, 0);
      acc_reg(3, 0, 0, 1, 1, 0);
      chk("R8 ns readback", r_data, 32'h1234_5689);
      chk("R8 ns walk attr", {28'b0, ns_walk_attr}, 32'h5);
      acc_reg(3, 1, 32'h0, 0, 1, 1);
      chk("R9 locked undef", {31'b0, r_undef}, 1);
      chk("R9 locked kept", {7'b0, s_tt_base}, 32'h01FF_FFFF);
      acc_reg(3, 0, 0, 0, 0, 0);
      chk("R8 user undef", {31'b0, r_undef}, 1);
      acc_reg(3, 0, 0, 0, 1, 0);
      chk("R8 secure copy kept", r_data, 32'hFFFF_FF9B);
   endtask

   task automatic t_unmapped();
      acc(0, 3'd0, 4'd1, 4'd1, 3'd3, 0, 0, 1, 0);
      chk("R1 op2=3 undef", {31'b0, r_undef}, 1);
      acc(0, 3'd1, 4'd1, 4'd1, 3'd0, 0, 0, 1, 0);
      chk("R1 op1=1 undef", {31'b0, r_undef}, 1);
      acc(0, 3'd0, 4'd2, 4'd1, 3'd0, 0, 0, 1, 0);
      chk("R1 crm=1 undef", {31'b0, r_undef}, 1);
      acc(1, 3'd0, 4'd3, 4'd1, 3'd2, 0, 0, 1, 0);
      chk("R1 crn=3 undef", {31'b0, r_undef}, 1);
      chk("R11 cp after unmapped", {18'b0, ns_cp_en}, 32'h0005);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            @(negedge clk);
            t_reset();
            t_abort();
            t_debug();
            t_nsacc();
            t_ttb();
            t_unmapped();
         end
         begin
            repeat (5000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule